// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides what a small 32-bit processor core does when it takes an exception. A request arrives with a 3-bit cause index, the program counter of the faulting instruction, the current interrupt-enable register, a remap flag and two vector base registers: one for ordinary exceptions and one for debug exceptions. One clock edge later the block presents the vector to jump to. It also presents a write strobe and data for whichever return-address register belongs to the cause's class, and the new value of the interrupt-enable register.

There are two classes. Ordinary causes save their return address and the prior enable state in one set of places. Debug causes use a separate set. The two kinds of return from exception are modelled as single-cycle pulses that put the saved enable bit back into the global enable bit. A cause index that names no exception raises an error pulse and changes nothing.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Causes 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call) are ordinary. They pulse `ea_we` and place the request's `cur_pc` on `ret_addr`. Causes 1 (breakpoint) and 3 (watchpoint) are debug. They pulse `ba_we` with the same return-address data.
- R2: For a valid cause, `pc_next` is the selected base with its low 8 bits dropped, plus 32 times the cause index. `pc_load` pulses at the same time.
- R3: Ordinary causes use `eba`, unless `remap` is 1, in which case they use `deba`. Debug causes always use `deba`.
- R4: The enable register uses this layout: bit 0 is the global enable, bit 1 is the saved bit for ordinary exceptions, and bit 2 is the saved bit for debug exceptions. On entry, `ie_we` pulses and `ie_out` bit 0 is 0.
- R5: On entry, the class's own saved bit becomes 1 if `ie_in` bit 0 was 1. Otherwise it keeps its `ie_in` value. The other class's saved bit is always copied unchanged.
- R6: Cause 0 with `exc_valid` pulses `bad_cause`. It raises none of `pc_load`, `ea_we`, `ba_we` or `ie_we`, even if a return pulse arrives in the same cycle.
- R7: Without an exception, `eret` writes `ie_in` with bit 0 replaced by bit 1. Otherwise `bret` writes `ie_in` with bit 0 replaced by bit 2. If both are high, `eret` wins.
- R8: An exception request takes priority over `eret` and `bret` in the same cycle.
- R9: During reset, and in any cycle after a cycle with no request and no return, all strobes are 0.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request |
| exc_cause | input | 3 | Cause index |
| cur_pc | input | 32 | Program counter of the excepting instruction |
| ie_in | input | 3 | Current enable register {saved-debug, saved-ordinary, global} |
| remap | input | 1 | Send ordinary causes to the debug base |
| eba | input | 32 | Ordinary vector base |
| deba | input | 32 | Debug vector base |
| eret | input | 1 | Return from ordinary exception |
| bret | input | 1 | Return from debug exception |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 32 | Vector address |
| ea_we | output | 1 | Write ordinary return-address register |
| ba_we | output | 1 | Write debug return-address register |
| ret_addr | output | 32 | Return-address write data |
| ie_we | output | 1 | Write enable register |
| ie_out | output | 3 | New enable register value |
| bad_cause | output | 1 | Unhandled cause index seen |

## Verification
The assertions check on every cycle that the two return-address strobes and the error pulse are mutually exclusive. They also check that an entry always clears the global enable, that vectors are slot-aligned, that a debug cause vectors into the debug base, and that the return address matches the previous cycle's program counter. An unhandled cause is checked to leave every strobe low. The bench sweeps every cause against every enable-register value, both remap settings and all four return-pulse combinations. Only that sweep shows the exact vector arithmetic, the set-only behaviour of the saved bits, and the priority between entry and the two returns.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int AW      = 32,
  parameter int CW      = 3,
  parameter int SLOT_LG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_cause,
  input  logic [AW-1:0] cur_pc,
  input  logic [2:0]    ie_in,
  input  logic          remap,
  input  logic [AW-1:0] eba,
  input  logic [AW-1:0] deba,
  input  logic          eret,
  input  logic          bret,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic          ea_we,
  output logic          ba_we,
  output logic [AW-1:0] ret_addr,
  output logic          ie_we,
  output logic [2:0]    ie_out,
  output logic          bad_cause
);
  localparam int VLOW = CW + SLOT_LG;
  localparam logic [CW-1:0] C_BKPT = CW'(1);
  localparam logic [CW-1:0] C_WTCH = CW'(3);
  localparam logic [CW-1:0] C_RST  = CW'(0);

  logic          is_dbg, is_norm;
  logic [AW-1:0] base, vec;
  logic [2:0]    ie_entry, ie_ret;

  assign is_dbg  = (exc_cause == C_BKPT) || (exc_cause == C_WTCH);
  assign is_norm = !is_dbg && (exc_cause != C_RST);
  assign base    = (is_dbg || remap) ? deba : eba;
  assign vec     = {base[AW-1:VLOW], exc_cause, {SLOT_LG{1'b0}}};

  assign ie_entry = {ie_in[2] | (is_dbg & ie_in[0]),
                     ie_in[1] | (is_norm & ie_in[0]),
                     1'b0};
  assign ie_ret   = eret ? {ie_in[2], ie_in[1], ie_in[1]}
                         : {ie_in[2], ie_in[1], ie_in[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load   <= 1'b0;
      pc_next   <= '0;
      ea_we     <= 1'b0;
      ba_we     <= 1'b0;
      ret_addr  <= '0;
      ie_we     <= 1'b0;
      ie_out    <= '0;
      bad_cause <= 1'b0;
    end else begin
      pc_load   <= 1'b0;
      ea_we     <= 1'b0;
      ba_we     <= 1'b0;
      ie_we     <= 1'b0;
      bad_cause <= 1'b0;
      if (exc_valid) begin
        if (!is_dbg && !is_norm) begin
          bad_cause <= 1'b1;
        end else begin
          pc_load  <= 1'b1;
          pc_next  <= vec;
          ret_addr <= cur_pc;
          ea_we    <= is_norm;
          ba_we    <= is_dbg;
          ie_we    <= 1'b1;
          ie_out   <= ie_entry;
        end
      end else if (eret || bret) begin
        ie_we  <= 1'b1;
        ie_out <= ie_ret;
      end
    end
  end
endmodule

module exc_entry_ctrl_chk #(
  parameter int AW      = 32,
  parameter int CW      = 3,
  parameter int SLOT_LG = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_valid,
  input logic [CW-1:0] exc_cause,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] deba,
  input logic          pc_load,
  input logic [AW-1:0] pc_next,
  input logic          ea_we,
  input logic          ba_we,
  input logic [AW-1:0] ret_addr,
  input logic          ie_we,
  input logic [2:0]    ie_out,
  input logic          bad_cause
);
  localparam int VLOW = CW + SLOT_LG;

  // R1
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_we, ba_we, bad_cause}));

  // R4
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (ie_we && !ie_out[0]));

  // R2
  slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_next[SLOT_LG-1:0] == '0));

  // R3
  dbg_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (exc_cause == CW'(1) || exc_cause == CW'(3)))
      |=> (ba_we && pc_next[AW-1:VLOW] == $past(deba[AW-1:VLOW])));

  // R1
  ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause != '0) |=> (ret_addr == $past(cur_pc)));

  // R6
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == '0)
      |=> (bad_cause && !pc_load && !ea_we && !ba_we && !ie_we));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.AW(AW), .CW(CW), .SLOT_LG(SLOT_LG)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        exc_valid = 0, remap = 0, eret = 0, bret = 0;
  logic [2:0]  exc_cause = 0, ie_in = 0;
  logic [31:0] cur_pc = 0, eba = 32'h1234_56FF, deba = 32'h89AB_CDEE;
  logic        pc_load, ea_we, ba_we, ie_we, bad_cause;
  logic [31:0] pc_next, ret_addr;
  logic [2:0]  ie_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_chk();
    chk("R9 idle strobes", {27'd0, pc_load, ea_we, ba_we, ie_we, bad_cause}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 idle_chk();
    chk("R9 reset pc_next", pc_next, 32'd0);
    chk("R9 reset ie_out", {29'd0, ie_out}, 32'd0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 idle_chk();

    for (int c = 0; c < 8; c++)
      for (int ie = 0; ie < 8; ie++)
        for (int rm = 0; rm < 2; rm++)
          for (int r = 0; r < 4; r++) begin
            logic dbg, nrm;
            logic [31:0] base, pc;
            logic [2:0] eie;
            @(negedge clk);
            pc = 32'h4000_0000 + 32'((c * 64 + ie * 8 + rm * 4 + r) * 4);
            exc_valid = 1; exc_cause = 3'(c); ie_in = 3'(ie); remap = rm[0];
            eret = r[0]; bret = r[1]; cur_pc = pc;
            dbg = (c == 1 || c == 3);
            nrm = (c != 0) && !dbg;
            base = (dbg || rm == 1) ? deba : eba;
            eie = {ie_in[2] | (dbg & ie_in[0]), ie_in[1] | (nrm & ie_in[0]), 1'b0};
            @(posedge clk); #1;
            if (c == 0) begin
              chk("R6 bad_cause", {31'd0, bad_cause}, 32'd1);
              chk("R6 no strobes R8", {28'd0, pc_load, ea_we, ba_we, ie_we}, 32'd0);
            end else begin
              chk("R1 ea_we", {31'd0, ea_we}, {31'd0, nrm});
              chk("R1 ba_we", {31'd0, ba_we}, {31'd0, dbg});
              chk("R1 ret_addr R10", ret_addr, pc);
              chk("R2 pc_load", {31'd0, pc_load}, 32'd1);
              chk("R2 R3 pc_next", pc_next, (base & ~32'hFF) + 32'(c * 32));
              chk("R4 ie_we", {31'd0, ie_we}, 32'd1);
              chk("R4 R5 R8 ie_out", {29'd0, ie_out}, {29'd0, eie});
            end
            @(negedge clk);
            exc_valid = 0; eret = 0; bret = 0;
            @(posedge clk); #1 idle_chk();
          end

    for (int ie = 0; ie < 8; ie++)
      for (int r = 1; r < 4; r++) begin
        logic [2:0] ie3, exp;
        @(negedge clk);
        ie3 = 3'(ie);
        ie_in = ie3; eret = r[0]; bret = r[1];
        exp = r[0] ? {ie3[2], ie3[1], ie3[1]} : {ie3[2], ie3[1], ie3[2]};
        @(posedge clk); #1;
        chk("R7 ie_we", {31'd0, ie_we}, 32'd1);
        chk("R7 ie_out", {29'd0, ie_out}, {29'd0, exp});
        chk("R7 no pc_load", {31'd0, pc_load}, 32'd0);
      end

    @(negedge clk); eret = 0; bret = 0;
    @(posedge clk); #1 idle_chk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule